// File: doc/BRIEF.md
# Triangular Down-Spread Ratio Generator

This block produces the fixed-point frequency-control word for the fractional-N feedback divider of a spread-spectrum clock synthesizer. It runs on a 27 MHz reference. The synthesized target is 100 MHz, so the unmodulated word is 100/27 held with 24 fractional bits. When spreading is enabled, the word falls linearly from that nominal value to a lower bound and then climbs back. This sweep repeats at about 32 kHz, and the peak frequency never rises above nominal.

Two select inputs pick the sweep depth. Each is a three-level pin that arrives here already resolved into a 2-bit code. The nine combinations map to off, six depths between 0.25% and 1.5%, and two test settings that behave like off but raise a flag. The block loads a new selection only when the sweep sits at its nominal apex, so the word never jumps. A settled output shows whether the depth in use matches the pins.

Top module: `ssc_profile_gen`

## Requirements
- R1: While reset is held, the ratio output equals the nominal word 62137837 (floor of 100·2^24/27), settled is high when both selects read low, and the test flag is low.
- R2: With the off setting loaded, the ratio equals the nominal word 62137837 on every cycle.
- R3: Each select is encoded as low=2'b00, middle=2'b01, high=2'b10, and 2'b11 behaves exactly like low.
- R4: Depth per (upper select, lower select) pair, expressed in units of 0.125%: (L,L)=0, (L,M)=4, (L,H)=3, (M,L)=2, (M,M)=6, (M,H)=8, (H,L)=12, (H,M)=0, (H,H)=0.
- R5: The sweep period is 844 reference cycles. A phase counter p runs from 0 to 843 and starts at 0 after reset. The ratio equals nominal − step·t, where t=p for p<422 and t=844−p otherwise.
- R6: The step for depth k is floor(62137837·k / (800·422)).
- R7: The selects are sampled only on the clock edge where p wraps from 843 to 0. A change at any other time leaves the ratio unchanged until that edge.
- R8: Settled is high exactly when the normalized selects equal the loaded pair. It is therefore high again at most 844 cycles after the last select change.
- R9: The two test pairs (H,M) and (H,H) give the nominal ratio and drive the test flag high. Every other loaded pair drives it low.
- R10: Between consecutive cycles the ratio moves by no more than the largest step, the one for depth 12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_hi | input | 2 | Resolved code of the upper select pin |
| sel_lo | input | 2 | Resolved code of the lower select pin |
| ratio_o | output | 32 | Divider ratio, 8 integer and 24 fractional bits |
| settled_o | output | 1 | Loaded depth matches the selects |
| test_o | output | 1 | A test setting is loaded |

## Verification
The ratio and the test flag change in the same cycle as the phase counter and loaded-setting registers. They are therefore due one edge after the phase wraps or advances. Settled is combinational on the selects and becomes valid right after a select change. The bench keeps its own phase and loaded-setting model, updated on rising edges. It compares all three outputs on every falling edge, so each expectation is sampled half a cycle after the edge that produced it. After each directed change it waits 845 cycles and then requires settled to be high.

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen #(
  parameter int FRAC    = 24,
  parameter int HALF    = 422,
  parameter int REF_MHZ = 27,
  parameter int OUT_MHZ = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  sel_hi,
  input  logic [1:0]  sel_lo,
  output logic [31:0] ratio_o,
  output logic        settled_o,
  output logic        test_o
);
  localparam int PERIOD = 2 * HALF;
  localparam int PW = $clog2(PERIOD + 1);
  localparam longint unsigned NOM64 = (64'(OUT_MHZ) << FRAC) / 64'(REF_MHZ);
  localparam logic [31:0] NOM = 32'(NOM64);

  function automatic logic [31:0] calc_step(input int k);
    return 32'((NOM64 * 64'(k)) / (64'(800) * 64'(HALF)));
  endfunction

  localparam logic [31:0] S2  = calc_step(2);
  localparam logic [31:0] S3  = calc_step(3);
  localparam logic [31:0] S4  = calc_step(4);
  localparam logic [31:0] S6  = calc_step(6);
  localparam logic [31:0] S8  = calc_step(8);
  localparam logic [31:0] S12 = calc_step(12);

  function automatic logic [1:0] nrm(input logic [1:0] c);
    return (c == 2'b11) ? 2'b00 : c;
  endfunction

  logic [PW-1:0] pos;
  logic [3:0]    cfg_q;
  logic [3:0]    cfg_in;
  logic [PW-1:0] sweep;
  logic [31:0]   step;
  logic          wrap;

  assign cfg_in = {nrm(sel_hi), nrm(sel_lo)};
  assign wrap   = (pos == PW'(PERIOD - 1));
  assign sweep  = (pos < PW'(HALF)) ? pos : PW'(PERIOD) - pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos   <= '0;
      cfg_q <= 4'b0000;
    end else begin
      pos <= wrap ? '0 : pos + 1'b1;
      if (wrap) cfg_q <= cfg_in;
    end
  end

  always_comb begin
    case (cfg_q)
      4'b0001: step = S4;
      4'b0010: step = S3;
      4'b0100: step = S2;
      4'b0101: step = S6;
      4'b0110: step = S8;
      4'b1000: step = S12;
      default: step = '0;
    endcase
  end

  assign ratio_o   = NOM - 32'(step * 32'(sweep));
  assign settled_o = (cfg_in == cfg_q);
  assign test_o    = (cfg_q[3:2] == 2'b10) && (cfg_q[1:0] != 2'b00);

  assert_ratio_capped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_o <= NOM);

  assert_smooth_slew_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((ratio_o >= $past(ratio_o)) ? (ratio_o - $past(ratio_o)) : ($past(ratio_o) - ratio_o)) <= S12);

  assert_test_is_nominal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    test_o |-> ratio_o == NOM);

  assert_load_at_apex_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> ratio_o == NOM);

  assert_settle_on_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(settled_o) && $stable(sel_hi) && $stable(sel_lo)) |-> ratio_o == NOM);
endmodule

// File: tb/test_ssc_profile_gen.sv
module test_ssc_profile_gen;
  localparam longint unsigned NOMB = 62137837;
  localparam int HALFB = 422;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] sel_hi = 2'b00, sel_lo = 2'b00;
  logic [31:0] ratio_o;
  logic settled_o, test_o;

  int total = 0, bad = 0;
  bit run = 1'b0;
  int mpos = 0;
  logic [1:0] mh = 2'b00, ml = 2'b00;
  logic [31:0] prev_ratio = 32'd62137837;

  always #5 clk = ~clk;

  ssc_profile_gen i_ssc_profile_gen (
    .clk(clk), .rst_n(rst_n), .sel_hi(sel_hi), .sel_lo(sel_lo),
    .ratio_o(ratio_o), .settled_o(settled_o), .test_o(test_o));

  // R3: 2'b11 reads as low
  function automatic logic [1:0] norm(input logic [1:0] c);
    return (c == 2'b11) ? 2'b00 : c;
  endfunction

  // R4: depth in 0.125% units
  function automatic int depth(input logic [1:0] h, input logic [1:0] l);
    int t [0:8] = '{0, 4, 3, 2, 6, 8, 12, 0, 0};
    return t[int'(h) * 3 + int'(l)];
  endfunction

  // R6
  function automatic longint unsigned stepf(input int k);
    return (NOMB * longint'(k)) / (800 * HALFB);
  endfunction

  function automatic logic [31:0] exp_ratio();
    int t;
    t = (mpos < HALFB) ? mpos : 2 * HALFB - mpos;
    return 32'(NOMB - stepf(depth(mh, ml)) * longint'(t));
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpos <= 0; mh <= 2'b00; ml <= 2'b00;
    end else if (mpos == 2 * HALFB - 1) begin
      mpos <= 0; mh <= norm(sel_hi); ml <= norm(sel_lo);  // R7
    end else begin
      mpos <= mpos + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && run) begin
      logic [31:0] e;
      longint d;
      e = exp_ratio();
      check(ratio_o == e, "R5 ratio", ratio_o, e);
      if (depth(mh, ml) == 0)
        check(ratio_o == 32'd62137837, "R2 nominal", ratio_o, 62137837);
      check(settled_o == ({norm(sel_hi), norm(sel_lo)} == {mh, ml}), "R8 settled",
            settled_o, {norm(sel_hi), norm(sel_lo)} == {mh, ml});
      check(test_o == (mh == 2'b10 && ml != 2'b00), "R9 test flag",
            test_o, mh == 2'b10 && ml != 2'b00);
      d = (ratio_o >= prev_ratio) ? longint'(ratio_o - prev_ratio) : longint'(prev_ratio - ratio_o);
      check(d <= longint'(stepf(12)), "R10 slew", d, stepf(12));
      prev_ratio = ratio_o;
    end
  end

  task automatic apply(input logic [1:0] h, input logic [1:0] l, input int cyc);
    @(negedge clk);
    sel_hi = h; sel_lo = l;
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check(ratio_o == 32'd62137837, "R1 reset ratio", ratio_o, 62137837);
    check(settled_o == 1'b1, "R1 reset settled", settled_o, 1);
    check(test_o == 1'b0, "R1 reset test", test_o, 0);
    rst_n = 1'b1;
    run = 1'b1;
    repeat (900) @(negedge clk);
    for (int c = 0; c < 9; c++) begin
      apply(2'(c / 3), 2'(c % 3), 845);
      check(settled_o == 1'b1, "R8 bound", settled_o, 1);
    end
    apply(2'b11, 2'b01, 845);
    check(settled_o == 1'b1, "R3 code 11", settled_o, 1);
    apply(2'b10, 2'b11, 845);
    check(test_o == 1'b0, "R3 code 11 as low", test_o, 0);
    for (int i = 0; i < 15; i++)
      apply(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), $urandom_range(40, 1800));
    apply(2'b01, 2'b10, 845);
    check(settled_o == 1'b1, "R8 final", settled_o, 1);
    run = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule